// File: doc/BRIEF.md
# Isolating Direct-Mapped Instruction Cache

This block sits between a processor's instruction fetch port and a word-addressed memory read port. It holds 4 KB of instructions in a direct-mapped array of 16-byte lines. The region byte of each fetch address (bits 31:24) decides whether the cache takes part. Only the two regions 0x00 and 0x80 are cacheable. Every other region, including the whole uncached window from 0xA0 upward, goes straight to memory as a single word read and leaves the cache untouched.

On a cacheable miss the block reads the whole line from memory, four words in ascending order, and stores them. It returns the requested word once the line is complete. Raising the isolate flag with a fetch suppresses that refill: the miss is served by a single memory read and no cache state changes. A hit returns the stored word even if memory has changed since, so stale code is kept on purpose. An invalidate-all input marks every line not present in one cycle.

Top module: `fc_icache`

## Requirements
- R1: A fetch is cacheable only when address bits 31:24 equal 0x00 or 0x80. A line is tagged with address bits 23:12, and lines are indexed by bits 11:4. A fetch to region 0x80 therefore hits a line that was filled through region 0x00 at the same 24-bit offset, and the reverse also holds.
- R2: A fetch to any other region issues exactly one memory read at the word-aligned fetch address and returns that data. Afterwards, a cacheable fetch to the same 24-bit offset still misses.
- R3: A cacheable miss with isolate low issues four memory reads at line base (address bits 3:0 cleared), base+4, base+8 and base+12, in that order. It returns the requested word after the fourth read completes.
- R4: A cacheable hit issues no memory read, and fetch_valid rises in the cycle after the fetch is accepted.
- R5: A fetch that has the same bits 11:4 as a cached line but different bits 23:12 misses and replaces that line.
- R6: A cacheable miss with isolate high issues exactly one memory read and returns its data, and it fills nothing: the same fetch misses again afterwards.
- R7: A cacheable hit with isolate high still returns the cached word without a memory read.
- R8: A hit returns the word stored at refill even after the memory contents at that address have changed.
- R9: A one-cycle pulse on invalidate makes every line not present, so the next cacheable fetch refills.
- R10: While invalidate is high, fetch_ready is low. An invalidate during a refill still lets that fetch deliver its word, but it leaves the line not present.
- R11: After reset, fetch_ready is high, fetch_valid and mem_req are low, and every line is not present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Fetch request, accepted when fetch_ready is high |
| fetch_pc | input | 32 | Fetch byte address |
| fetch_isolate | input | 1 | Suppress refill on a miss |
| fetch_ready | output | 1 | Block can accept a fetch this cycle |
| fetch_valid | output | 1 | One-cycle pulse with the fetched word |
| fetch_instr | output | 32 | Fetched instruction word |
| invalidate | input | 1 | Mark all lines not present |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Word-aligned memory read address |
| mem_rvalid | input | 1 | Read data valid, one pulse per request |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions assume that memory answers each one-cycle request with exactly one mem_rvalid pulse, at least one cycle later, and never sends a response that nobody asked for. They also assume that fetch_req is only treated as accepted while fetch_ready is high. The bench's memory model gives every request a fixed two-cycle latency and never overlaps responses. The bench drives a fetch only after it has seen fetch_ready high, and it drops the request after the accepting edge. Invalidate pulses are applied while the block is idle and also in the middle of a refill, so the abort path is exercised under the same protocol.

// File: rtl/fc_pkg.sv
package fc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_PASS = 2'd2
   } fc_state_e;

   localparam logic [7:0] RGN_LOW_CACHED  = 8'h00;
   localparam logic [7:0] RGN_HIGH_CACHED = 8'h80;
endpackage

// File: rtl/fc_region_decode.sv
module fc_region_decode #(
   parameter int RGN_W = 8
) (
   input  logic [RGN_W-1:0] region,
   output logic             cacheable
);
   import fc_pkg::*;

   if (RGN_W != 8) begin : g_bad_width
      $error("fc_region_decode: region field must be 8 bits");
   end

   always_comb begin
      cacheable = (region == RGN_LOW_CACHED) || (region == RGN_HIGH_CACHED);
   end
endmodule

// File: rtl/fc_tag_store.sv
module fc_tag_store #(
   parameter int NUM_LINES = 256,
   parameter int TAG_W     = 12,
   localparam int IDX_W    = $clog2(NUM_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_all,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_present,
   output logic [TAG_W-1:0] rd_tag,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag
);
   logic [NUM_LINES-1:0] present_q;
   logic [TAG_W-1:0]     tag_q [NUM_LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         present_q <= '0;
      end else if (clear_all) begin
         present_q <= '0;
      end else if (wr_en) begin
         present_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
      end
   end

   assign rd_present = present_q[rd_idx];
   assign rd_tag     = tag_q[rd_idx];
endmodule

// File: rtl/fc_data_store.sv
module fc_data_store #(
   parameter int NUM_LINES  = 256,
   parameter int LINE_WORDS = 4,
   parameter int DATA_W     = 32,
   localparam int IDX_W     = $clog2(NUM_LINES),
   localparam int WSEL_W    = $clog2(LINE_WORDS)
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [WSEL_W-1:0] rd_word,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WSEL_W-1:0] wr_word,
   input  logic [DATA_W-1:0] wr_data
);
   logic [DATA_W-1:0] bank_out [LINE_WORDS];

   for (genvar w = 0; w < LINE_WORDS; w++) begin : g_bank
      logic [DATA_W-1:0] mem_q [NUM_LINES];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_word == WSEL_W'(w))) begin
            mem_q[wr_idx] <= wr_data;
         end
      end
      assign bank_out[w] = mem_q[rd_idx];
   end

   assign rd_data = bank_out[rd_word];
endmodule

// File: rtl/fc_icache.sv
module fc_icache #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int CACHE_BYTES = 4096,
   parameter int LINE_BYTES  = 16,
   parameter int OFFSET_W    = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_pc,
   input  logic              fetch_isolate,
   output logic              fetch_ready,
   output logic              fetch_valid,
   output logic [DATA_W-1:0] fetch_instr,
   input  logic              invalidate,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata
);
   import fc_pkg::*;

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int WORD_SH    = $clog2(WORD_BYTES);
   localparam int LINE_SH    = $clog2(LINE_BYTES);
   localparam int IDX_SH     = $clog2(CACHE_BYTES);
   localparam int LINE_WORDS = LINE_BYTES / WORD_BYTES;
   localparam int NUM_LINES  = CACHE_BYTES / LINE_BYTES;
   localparam int LIDX_W     = IDX_SH - LINE_SH;
   localparam int WSEL_W     = LINE_SH - WORD_SH;
   localparam int TAG_W      = OFFSET_W - IDX_SH;
   localparam int RGN_W      = ADDR_W - OFFSET_W;
   localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(LINE_WORDS - 1);

   if (ADDR_W != 32 || DATA_W != 32) begin : g_bad_bus
      $error("fc_icache: address and data buses must be 32 bits");
   end
   if (LINE_WORDS < 2 || (1 << LINE_SH) != LINE_BYTES) begin : g_bad_line
      $error("fc_icache: line must be a power of two of at least two words");
   end
   if ((1 << IDX_SH) != CACHE_BYTES || IDX_SH >= OFFSET_W) begin : g_bad_size
      $error("fc_icache: cache size must be a power of two below the offset span");
   end

   fc_state_e                 state_q;
   logic [ADDR_W-1:WORD_SH]   pc_q;
   logic [WSEL_W-1:0]         cnt_q;
   logic                      issued_q;
   logic                      poison_q;
   logic [DATA_W-1:0]         grab_q;
   logic                      out_valid_q;
   logic [DATA_W-1:0]         out_data_q;

   logic                      cacheable;
   logic                      present;
   logic [TAG_W-1:0]          stored_tag;
   logic [DATA_W-1:0]         cached_word;
   logic                      hit;
   logic                      accept;
   logic                      fill_busy;
   logic                      fill_rsp;
   logic                      tag_we;
   logic [WSEL_W-1:0]         want_word;

   fc_region_decode #(.RGN_W(RGN_W)) i_region (
      .region    (fetch_pc[ADDR_W-1:OFFSET_W]),
      .cacheable (cacheable)
   );

   fc_tag_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) i_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_all  (invalidate),
      .rd_idx     (fetch_pc[IDX_SH-1:LINE_SH]),
      .rd_present (present),
      .rd_tag     (stored_tag),
      .wr_en      (tag_we),
      .wr_idx     (pc_q[IDX_SH-1:LINE_SH]),
      .wr_tag     (pc_q[OFFSET_W-1:IDX_SH])
   );

   fc_data_store #(.NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) i_data (
      .clk     (clk),
      .rd_idx  (fetch_pc[IDX_SH-1:LINE_SH]),
      .rd_word (fetch_pc[LINE_SH-1:WORD_SH]),
      .rd_data (cached_word),
      .wr_en   (fill_rsp),
      .wr_idx  (pc_q[IDX_SH-1:LINE_SH]),
      .wr_word (cnt_q),
      .wr_data (mem_rdata)
   );

   assign hit         = cacheable && present && (stored_tag == fetch_pc[OFFSET_W-1:IDX_SH]);
   assign fetch_ready = (state_q == ST_IDLE) && !invalidate;
   assign accept      = fetch_req && fetch_ready;
   assign fill_busy   = (state_q == ST_FILL);
   assign fill_rsp    = fill_busy && mem_rvalid;
   assign want_word   = pc_q[LINE_SH-1:WORD_SH];
   assign tag_we      = fill_rsp && (cnt_q == LAST_WORD) && !poison_q && !invalidate;
   assign mem_req     = (state_q != ST_IDLE) && !issued_q;

   always_comb begin
      if (fill_busy) begin
         mem_addr = {pc_q[ADDR_W-1:LINE_SH], cnt_q, {WORD_SH{1'b0}}};
      end else begin
         mem_addr = {pc_q, {WORD_SH{1'b0}}};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         pc_q        <= '0;
         cnt_q       <= '0;
         issued_q    <= 1'b0;
         poison_q    <= 1'b0;
         grab_q      <= '0;
         out_valid_q <= 1'b0;
         out_data_q  <= '0;
      end else begin
         out_valid_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  pc_q     <= fetch_pc[ADDR_W-1:WORD_SH];
                  cnt_q    <= '0;
                  issued_q <= 1'b0;
                  poison_q <= 1'b0;
                  if (hit) begin
                     out_valid_q <= 1'b1;
                     out_data_q  <= cached_word;
                  end else if (cacheable && !fetch_isolate) begin
                     state_q <= ST_FILL;
                  end else begin
                     state_q <= ST_PASS;
                  end
               end
            end
            ST_FILL: begin
               if (invalidate) begin
                  poison_q <= 1'b1;
               end
               if (mem_req) begin
                  issued_q <= 1'b1;
               end
               if (mem_rvalid) begin
                  issued_q <= 1'b0;
                  if (cnt_q == want_word) begin
                     grab_q <= mem_rdata;
                  end
                  if (cnt_q == LAST_WORD) begin
                     state_q     <= ST_IDLE;
                     out_valid_q <= 1'b1;
                     out_data_q  <= (cnt_q == want_word) ? mem_rdata : grab_q;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_PASS: begin
               if (mem_req) begin
                  issued_q <= 1'b1;
               end
               if (mem_rvalid) begin
                  issued_q    <= 1'b0;
                  state_q     <= ST_IDLE;
                  out_valid_q <= 1'b1;
                  out_data_q  <= mem_rdata;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign fetch_valid = out_valid_q;
   assign fetch_instr = out_data_q;
endmodule

// File: rtl/fc_icache_chk.sv
module fc_icache_chk #(
   parameter int ADDR_W  = 32,
   parameter int LINE_SH = 4,
   parameter int WORD_SH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_req,
   input logic [ADDR_W-1:0] fetch_pc,
   input logic              fetch_isolate,
   input logic              fetch_ready,
   input logic              fetch_valid,
   input logic              invalidate,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              lookup_hit,
   input logic              fill_busy
);
   logic [ADDR_W-1:0] prev_fill_q;
   logic              acc;
   logic              rgn_cached;

   assign acc        = fetch_req && fetch_ready;
   assign rgn_cached = (fetch_pc[ADDR_W-1:ADDR_W-8] == 8'h00) ||
                       (fetch_pc[ADDR_W-1:ADDR_W-8] == 8'h80);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_fill_q <= '0;
      end else if (mem_req && fill_busy) begin
         prev_fill_q <= mem_addr;
      end
   end

   AST_BYPASS_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !rgn_cached) |=> !fill_busy); // R2

   AST_FILL_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && fill_busy && (mem_addr[LINE_SH-1:WORD_SH] != '0))
      |-> (mem_addr == prev_fill_q + (ADDR_W'(1) << WORD_SH))); // R3

   AST_MEM_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req); // R3

   AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && lookup_hit) |=> (fetch_valid && !mem_req)); // R4

   AST_ISOLATE_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && fetch_isolate && !lookup_hit) |=> !fill_busy); // R6

   AST_INVAL_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      invalidate |-> !fetch_ready); // R10

   AST_NO_MEM_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !fetch_ready); // R11
endmodule

bind fc_icache fc_icache_chk #(
   .ADDR_W  (ADDR_W),
   .LINE_SH (LINE_SH),
   .WORD_SH (WORD_SH)
) i_fc_icache_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .fetch_req     (fetch_req),
   .fetch_pc      (fetch_pc),
   .fetch_isolate (fetch_isolate),
   .fetch_ready   (fetch_ready),
   .fetch_valid   (fetch_valid),
   .invalidate    (invalidate),
   .mem_req       (mem_req),
   .mem_addr      (mem_addr),
   .lookup_hit    (hit),
   .fill_busy     (fill_busy)
);

// File: tb/test_fc_icache.sv
`timescale 1ns/1ps
module test_fc_icache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_req = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        fetch_isolate = 1'b0;
   logic        fetch_ready;
   logic        fetch_valid;
   logic [31:0] fetch_instr;
   logic        invalidate = 1'b0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid;
   logic [31:0] mem_rdata;

   int checks = 0;
   int errors = 0;
   int nrd = 0;
   logic [31:0] rd_log [8];
   logic [7:0] ver = 8'h00;
   bit done = 1'b0;

   logic        p1 = 1'b0, p2 = 1'b0;
   logic [31:0] a1 = '0, a2 = '0;

   always #4 clk = ~clk;

   fc_icache i_fc_icache (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_pc(fetch_pc),
      .fetch_isolate(fetch_isolate), .fetch_ready(fetch_ready),
      .fetch_valid(fetch_valid), .fetch_instr(fetch_instr),
      .invalidate(invalidate), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   function automatic logic [31:0] memf(input logic [31:0] a, input logic [7:0] v);
      return a ^ 32'h5A5A_0000 ^ {v, 24'h0};
   endfunction

   always @(posedge clk) begin
      p1 <= mem_req;
      a1 <= mem_addr;
      p2 <= p1;
      a2 <= a1;
      if (mem_req) begin
         if (nrd < 8) rd_log[nrd] = mem_addr;
         nrd = nrd + 1;
      end
   end
   assign mem_rvalid = p2;
   assign mem_rdata  = memf(a2, ver);

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_fetch(input logic [31:0] pc, input bit iso,
                           output logic [31:0] d, output int lat);
      @(negedge clk);
      while (!fetch_ready) @(negedge clk);
      nrd = 0;
      fetch_req = 1'b1; fetch_pc = pc; fetch_isolate = iso;
      @(negedge clk);
      fetch_req = 1'b0;
      lat = 1;
      while (!fetch_valid && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      d = fetch_instr;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R11", "ready", 32'(fetch_ready), 32'd1);
      chk("R11", "valid", 32'(fetch_valid), 32'd0);
      chk("R11", "mem_req", 32'(mem_req), 32'd0);
   endtask

   task automatic t_fill_and_hit();
      logic [31:0] d; int lat;
      do_fetch(32'h0000_0128, 1'b0, d, lat);
      chk("R3", "fill reads", nrd, 4);
      for (int i = 0; i < 4; i++)
         chk("R3", "fill order", rd_log[i], 32'h0000_0120 + 32'(4 * i));
      chk("R3", "fill data", d, memf(32'h0000_0128, ver));
      do_fetch(32'h0000_012C, 1'b0, d, lat);
      chk("R4", "hit latency", lat, 1);
      chk("R4", "hit reads", nrd, 0);
      chk("R4", "hit data", d, memf(32'h0000_012C, ver));
   endtask

   task automatic t_alias();
      logic [31:0] d; int lat;
      do_fetch(32'h8000_0124, 1'b0, d, lat);
      chk("R1", "alias reads", nrd, 0);
      chk("R1", "alias data", d, memf(32'h0000_0124, ver));
      do_fetch(32'h0000_1124, 1'b0, d, lat);
      chk("R5", "other tag reads", nrd, 4);
      chk("R5", "other tag data", d, memf(32'h0000_1124, ver));
      do_fetch(32'h0000_0124, 1'b0, d, lat);
      chk("R5", "replaced reads", nrd, 4);
   endtask

   task automatic t_uncached();
      logic [31:0] d; int lat;
      do_fetch(32'hA000_0302, 1'b0, d, lat);
      chk("R2", "high reads", nrd, 1);
      chk("R2", "high addr", rd_log[0], 32'hA000_0300);
      chk("R2", "high data", d, memf(32'hA000_0300, ver));
      do_fetch(32'h4000_0304, 1'b0, d, lat);
      chk("R2", "mid region reads", nrd, 1);
      chk("R2", "mid region data", d, memf(32'h4000_0304, ver));
      do_fetch(32'h0000_0300, 1'b0, d, lat);
      chk("R2", "no fill left", nrd, 4);
   endtask

   task automatic t_isolate();
      logic [31:0] d; int lat;
      do_fetch(32'h0000_0408, 1'b1, d, lat);
      chk("R6", "iso reads", nrd, 1);
      chk("R6", "iso data", d, memf(32'h0000_0408, ver));
      do_fetch(32'h0000_0408, 1'b1, d, lat);
      chk("R6", "iso still miss", nrd, 1);
      do_fetch(32'h0000_0408, 1'b0, d, lat);
      chk("R6", "fill after iso", nrd, 4);
      do_fetch(32'h0000_0404, 1'b1, d, lat);
      chk("R7", "iso hit reads", nrd, 0);
      chk("R7", "iso hit data", d, memf(32'h0000_0404, ver));
   endtask

   task automatic t_stale();
      logic [31:0] d; int lat;
      ver = 8'h11;
      do_fetch(32'h0000_040C, 1'b0, d, lat);
      chk("R8", "stale reads", nrd, 0);
      chk("R8", "stale data", d, memf(32'h0000_040C, 8'h00));
   endtask

   task automatic t_invalidate();
      logic [31:0] d; int lat;
      @(negedge clk);
      invalidate = 1'b1;
      #1;
      chk("R10", "ready during inval", 32'(fetch_ready), 32'd0);
      @(negedge clk);
      invalidate = 1'b0;
      do_fetch(32'h0000_040C, 1'b0, d, lat);
      chk("R9", "refill reads", nrd, 4);
      chk("R9", "new data", d, memf(32'h0000_040C, ver));
   endtask

   task automatic t_inval_in_fill();
      logic [31:0] d; int lat;
      @(negedge clk);
      while (!fetch_ready) @(negedge clk);
      fetch_req = 1'b1; fetch_pc = 32'h0000_0504; fetch_isolate = 1'b0;
      @(negedge clk);
      fetch_req = 1'b0;
      repeat (3) @(negedge clk);
      invalidate = 1'b1;
      @(negedge clk);
      invalidate = 1'b0;
      lat = 0;
      while (!fetch_valid && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      chk("R10", "word after abort", fetch_instr, memf(32'h0000_0504, ver));
      do_fetch(32'h0000_0504, 1'b0, d, lat);
      chk("R10", "line not kept", nrd, 4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill_and_hit();
      t_alias();
      t_uncached();
      t_isolate();
      t_stale();
      t_invalidate();
      t_inval_in_fill();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule